// File: doc/BRIEF.md
# Command-Byte Register Access Controller

This block sits behind a serial bus slave that has already framed the traffic into whole bytes. For each transaction it gets a start pulse, then a stream of written bytes and read requests. When the first written byte of a transaction has its top bit set, the block treats it as a command. The command carries a 5-bit register pointer, a 2-bit transfer type and, for one of the types, a special-function code. Every later byte is written to the register the pointer names, and every read request returns that register. Depending on the stored type, the pointer either stays put or advances after each access. The pointer and type persist across transactions.

The register map holds the light-measurement configuration: the enable bits, integration and wait periods, two 16-bit interrupt thresholds, persistence, the long-wait option, gain, a fixed identity byte and a status byte. It also holds four 16-bit result channels, loaded together when a measurement completes. Reading the low byte of a channel freezes that channel's high byte in a shadow register, so the two bytes always belong to the same measurement. One special-function code clears the interrupt flag.

Top module: `cmdreg_ctrl`

## Requirements
- R1: In the first write byte after `xfer_start`, bit 7 = 1 marks a command. Bits 4:0 become the pointer and bits 6:5 the transfer type (00 repeat, 01 auto-increment, 10 reserved and handled as repeat, 11 special function). A command byte is never stored as register data.
- R2: With type 00, every data write and every read uses the same pointer, which does not move.
- R3: With type 01, the pointer increments after each data write or read, and it wraps from 0x1F to 0x00.
- R4: A first write byte with bit 7 = 0 is data, written at the stored pointer. The pointer and type survive across transactions, and a read with no command in its transaction uses the stored pointer.
- R5: A type-11 command with code 00110 (byte 0xE6) clears the interrupt flag. A type-11 command changes neither the pointer nor the type, and any other code has no effect.
- R6: The map and its writable bits are as follows. 0x00 enable: bit4 interrupt enable, bit3 wait enable, bit1 measurement enable, bit0 power. 0x01 integration period and 0x03 wait period, both resetting to 0xFF. 0x04/0x05 low threshold (low byte first). 0x06/0x07 high threshold. 0x0C persistence in bits 3:0. 0x0D long-wait in bit 1. 0x0F gain in bits 1:0. 0x12 identity, set by the `ID_VALUE` parameter. 0x13 status. Reserved bits read 0, and every other register resets to 0.
- R7: Writes to read-only or unmapped addresses are discarded, and reads of unmapped addresses return 0x00. Configuration outputs change only in response to a write.
- R8: A `result_valid` pulse loads all four channels from `result_bus`, whose 16-bit slices in ascending order are clear, red, green and blue. The channels read at 0x14–0x1B in that order, low byte first. The same pulse sets status bit 0.
- R9: Reading a channel's low byte copies that channel's high byte into the channel's shadow. A high-byte read returns the shadow, even if newer results have arrived in between.
- R10: An `irq_set` pulse sets the interrupt flag, which reads as status bit 4. `irq_out` is the flag gated by enable bit 4. When `irq_set` and the clear command land in the same cycle, the set wins.
- R11: `rd_data` and `rd_valid` appear in the cycle after a read request. A read request that coincides with `wr_valid` is ignored. Configuration outputs change on the edge that takes the write.
- R12: After reset the pointer and type are 0, both periods are 0xFF, and the flags, thresholds and channels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Start of a bus transaction |
| wr_valid | input | 1 | A written byte is present |
| wr_byte | input | 8 | Written byte |
| rd_req | input | 1 | Read request for one byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` holds a fresh byte |
| result_valid | input | 1 | New measurement results |
| result_bus | input | 64 | Four 16-bit results, clear in the lowest slice |
| irq_set | input | 1 | Threshold logic requests an interrupt |
| en_power | output | 1 | Power enable bit |
| en_meas | output | 1 | Measurement enable bit |
| en_wait | output | 1 | Wait enable bit |
| en_irq | output | 1 | Interrupt enable bit |
| integ_time | output | 8 | Integration period register |
| wait_time | output | 8 | Wait period register |
| thr_low | output | 16 | Low threshold |
| thr_high | output | 16 | High threshold |
| persist | output | 4 | Persistence code |
| wait_long | output | 1 | Long-wait option |
| gain | output | 2 | Gain code |
| irq_flag | output | 1 | Pending interrupt flag |
| irq_out | output | 1 | Interrupt output after enable gating |

## Verification
A channel low-byte read can fall in the same cycle as a new-results pulse. The bench drives both in one cycle and expects the read to return the old low byte. It then expects the following high-byte read to return the old high byte, not the new one, and a later fresh low-byte read to show the new result. The interrupt-clear command can likewise coincide with `irq_set`. The bench issues both together and expects the flag to remain set, then clears it alone and expects it low.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

   typedef enum logic [1:0] {
      XT_REPEAT  = 2'b00,
      XT_AUTO    = 2'b01,
      XT_RSVD    = 2'b10,
      XT_SPECIAL = 2'b11
   } xfer_type_e;

   localparam logic [4:0] SF_IRQ_CLR = 5'b00110;

   localparam logic [4:0] A_IDENT = 5'h12;
   localparam logic [4:0] A_STAT  = 5'h13;
   localparam logic [4:0] A_DATA0 = 5'h14;

   localparam int N_CFG = 10;
   localparam int IX_EN = 0, IX_ITIME = 1, IX_WTIME = 2, IX_TLO_L = 3, IX_TLO_H = 4;
   localparam int IX_THI_L = 5, IX_THI_H = 6, IX_PERS = 7, IX_CFG = 8, IX_CTRL = 9;

   localparam logic [4:0] CFG_ADDR [N_CFG] = '{
      5'h00, 5'h01, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h0C, 5'h0D, 5'h0F};
   localparam logic [7:0] CFG_MASK [N_CFG] = '{
      8'h1B, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h0F, 8'h02, 8'h03};
   localparam logic [7:0] CFG_RST  [N_CFG] = '{
      8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

endpackage

// File: rtl/cmdreg_decode.sv
module cmdreg_decode
   import cmdreg_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              rd_req,
   output logic [ADDR_W-1:0] ptr,
   output xfer_type_e        xtype,
   output logic              data_we,
   output logic              rd_fire,
   output logic              sf_irq_clr
);

   localparam int SEL_BIT = DATA_W - 1;

   logic              first_q;
   logic [ADDR_W-1:0] ptr_q;
   xfer_type_e        type_q;
   logic              cmd_hit;
   logic              special;
   logic              step;
   xfer_type_e        new_type;

   assign new_type   = xfer_type_e'(wr_byte[6:5]);
   assign cmd_hit    = wr_valid && first_q && wr_byte[SEL_BIT];
   assign special    = cmd_hit && (new_type == XT_SPECIAL);
   assign data_we    = wr_valid && !cmd_hit;
   assign rd_fire    = rd_req && !wr_valid;
   assign sf_irq_clr = special && (wr_byte[4:0] == SF_IRQ_CLR);
   assign step       = (data_we || rd_fire) && (type_q == XT_AUTO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b0;
         ptr_q   <= '0;
         type_q  <= XT_REPEAT;
      end else begin
         if (xfer_start)
            first_q <= 1'b1;
         else if (wr_valid || rd_fire)
            first_q <= 1'b0;

         if (cmd_hit && !special) begin
            ptr_q  <= wr_byte[ADDR_W-1:0];
            type_q <= new_type;
         end else if (step) begin
            ptr_q  <= ptr_q + 1'b1;
         end
      end
   end

   assign ptr   = ptr_q;
   assign xtype = type_q;

endmodule

// File: rtl/cmdreg_cfg.sv
module cmdreg_cfg
   import cmdreg_pkg::*;
#(
   parameter int          ADDR_W   = 5,
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  ID_VALUE = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              result_valid,
   input  logic              irq_set,
   input  logic              irq_clr,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] reg_out [N_CFG],
   output logic              irq_flag,
   output logic              valid_flag
);

   logic [DATA_W-1:0] reg_q [N_CFG];
   logic              irq_q;
   logic              valid_q;

   for (genvar i = 0; i < N_CFG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reg_q[i] <= CFG_RST[i];
         else if (we && (addr == CFG_ADDR[i]))
            reg_q[i] <= wdata & CFG_MASK[i];
      end
      assign reg_out[i] = reg_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         if (irq_set)
            irq_q <= 1'b1;
         else if (irq_clr)
            irq_q <= 1'b0;
         if (result_valid)
            valid_q <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_CFG; i++)
         if (addr == CFG_ADDR[i])
            rdata = reg_q[i];
      if (addr == A_IDENT)
         rdata = ID_VALUE;
      if (addr == A_STAT)
         rdata = {3'b000, irq_q, 3'b000, valid_q};
   end

   assign irq_flag   = irq_q;
   assign valid_flag = valid_q;

endmodule

// File: rtl/cmdreg_data.sv
module cmdreg_data
   import cmdreg_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int N_CHAN = 4,
   parameter int CHAN_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     result_valid,
   input  logic [N_CHAN*CHAN_W-1:0] result_bus,
   input  logic                     rd_fire,
   input  logic [ADDR_W-1:0]        addr,
   output logic [DATA_W-1:0]        rdata
);

   logic [DATA_W-1:0] ch_rd [N_CHAN];

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(A_DATA0 + 2*c);
      localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(A_DATA0 + 2*c + 1);

      logic [CHAN_W-1:0] val_q;
      logic [DATA_W-1:0] shadow_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q    <= '0;
            shadow_q <= '0;
         end else begin
            if (result_valid)
               val_q <= result_bus[c*CHAN_W +: CHAN_W];
            if (rd_fire && (addr == LO_ADDR))
               shadow_q <= val_q[CHAN_W-1 -: DATA_W];
         end
      end

      always_comb begin
         ch_rd[c] = '0;
         if (addr == LO_ADDR)
            ch_rd[c] = val_q[DATA_W-1:0];
         else if (addr == HI_ADDR)
            ch_rd[c] = shadow_q;
      end
   end

   always_comb begin
      rdata = '0;
      for (int c = 0; c < N_CHAN; c++)
         rdata = rdata | ch_rd[c];
   end

endmodule

// File: rtl/cmdreg_ctrl.sv
module cmdreg_ctrl
   import cmdreg_pkg::*;
#(
   parameter int         ADDR_W   = 5,
   parameter int         DATA_W   = 8,
   parameter int         N_CHAN   = 4,
   parameter int         CHAN_W   = 16,
   parameter logic [7:0] ID_VALUE = 8'h5A
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     xfer_start,
   input  logic                     wr_valid,
   input  logic [DATA_W-1:0]        wr_byte,
   input  logic                     rd_req,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_valid,
   input  logic                     result_valid,
   input  logic [N_CHAN*CHAN_W-1:0] result_bus,
   input  logic                     irq_set,
   output logic                     en_power,
   output logic                     en_meas,
   output logic                     en_wait,
   output logic                     en_irq,
   output logic [7:0]               integ_time,
   output logic [7:0]               wait_time,
   output logic [15:0]              thr_low,
   output logic [15:0]              thr_high,
   output logic [3:0]               persist,
   output logic                     wait_long,
   output logic [1:0]               gain,
   output logic                     irq_flag,
   output logic                     irq_out
);

   localparam int MAP_SIZE = 2 ** ADDR_W;
   localparam int DATA_END = int'(A_DATA0) + 2 * N_CHAN;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("cmdreg_ctrl: DATA_W must be 8");
   end
   if (ADDR_W != 5) begin : g_bad_addr_w
      $error("cmdreg_ctrl: ADDR_W must be 5");
   end
   if (CHAN_W != 2 * DATA_W) begin : g_bad_chan_w
      $error("cmdreg_ctrl: CHAN_W must be twice DATA_W");
   end
   if (DATA_END > MAP_SIZE) begin : g_bad_n_chan
      $error("cmdreg_ctrl: channels exceed the address space");
   end

   logic [ADDR_W-1:0] ptr;
   xfer_type_e        xtype;
   logic              data_we;
   logic              rd_fire;
   logic              sf_irq_clr;
   logic              valid_flag;
   logic [DATA_W-1:0] cfg_rdata;
   logic [DATA_W-1:0] dat_rdata;
   logic [DATA_W-1:0] regs [N_CFG];
   logic [DATA_W-1:0] rd_data_q;
   logic              rd_valid_q;

   cmdreg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_start (xfer_start),
      .wr_valid   (wr_valid),
      .wr_byte    (wr_byte),
      .rd_req     (rd_req),
      .ptr        (ptr),
      .xtype      (xtype),
      .data_we    (data_we),
      .rd_fire    (rd_fire),
      .sf_irq_clr (sf_irq_clr)
   );

   cmdreg_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .we           (data_we),
      .addr         (ptr),
      .wdata        (wr_byte),
      .result_valid (result_valid),
      .irq_set      (irq_set),
      .irq_clr      (sf_irq_clr),
      .rdata        (cfg_rdata),
      .reg_out      (regs),
      .irq_flag     (irq_flag),
      .valid_flag   (valid_flag)
   );

   cmdreg_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CHAN(N_CHAN), .CHAN_W(CHAN_W)) u_data (
      .clk          (clk),
      .rst_n        (rst_n),
      .result_valid (result_valid),
      .result_bus   (result_bus),
      .rd_fire      (rd_fire),
      .addr         (ptr),
      .rdata        (dat_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= rd_fire;
         if (rd_fire)
            rd_data_q <= cfg_rdata | dat_rdata;
      end
   end

   assign rd_data    = rd_data_q;
   assign rd_valid   = rd_valid_q;
   assign en_power   = regs[IX_EN][0];
   assign en_meas    = regs[IX_EN][1];
   assign en_wait    = regs[IX_EN][3];
   assign en_irq     = regs[IX_EN][4];
   assign integ_time = regs[IX_ITIME];
   assign wait_time  = regs[IX_WTIME];
   assign thr_low    = {regs[IX_TLO_H], regs[IX_TLO_L]};
   assign thr_high   = {regs[IX_THI_H], regs[IX_THI_L]};
   assign persist    = regs[IX_PERS][3:0];
   assign wait_long  = regs[IX_CFG][1];
   assign gain       = regs[IX_CTRL][1:0];
   assign irq_out    = irq_flag & en_irq;

endmodule

// File: rtl/cmdreg_ctrl_chk.sv
module cmdreg_ctrl_chk
   import cmdreg_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              rd_fire,
   input logic              rd_valid,
   input logic              data_we,
   input logic [ADDR_W-1:0] ptr,
   input xfer_type_e        xtype,
   input logic              irq_set,
   input logic              sf_irq_clr,
   input logic              irq_flag,
   input logic              result_valid,
   input logic              valid_flag,
   input logic [7:0]        integ_time
);

   p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> rd_valid);

   p_auto_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_we || rd_fire) && xtype == XT_AUTO) |=> (ptr == $past(ptr) + 1'b1));

   p_repeat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_we || rd_fire) && xtype == XT_REPEAT) |=> $stable(ptr));

   p_irq_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> irq_flag);

   p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !sf_irq_clr) |=> irq_flag);

   p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_irq_clr && !irq_set) |=> !irq_flag);

   p_valid_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> valid_flag);

   p_cfg_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> $stable(integ_time));

endmodule

bind cmdreg_ctrl cmdreg_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_valid     (wr_valid),
   .rd_fire      (rd_fire),
   .rd_valid     (rd_valid),
   .data_we      (data_we),
   .ptr          (ptr),
   .xtype        (xtype),
   .irq_set      (irq_set),
   .sf_irq_clr   (sf_irq_clr),
   .irq_flag     (irq_flag),
   .result_valid (result_valid),
   .valid_flag   (valid_flag),
   .integ_time   (integ_time)
);

// File: tb/tb_cmdreg_ctrl.sv
module tb_cmdreg_ctrl;

   localparam logic [7:0] TB_ID = 8'hC3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_start = 1'b0;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_byte = '0;
   logic        rd_req = 1'b0;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        result_valid = 1'b0;
   logic [63:0] result_bus = '0;
   logic        irq_set = 1'b0;
   logic        en_power, en_meas, en_wait, en_irq;
   logic [7:0]  integ_time, wait_time;
   logic [15:0] thr_low, thr_high;
   logic [3:0]  persist;
   logic        wait_long;
   logic [1:0]  gain;
   logic        irq_flag, irq_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] rb;

   always #2.5 clk = ~clk;

   cmdreg_ctrl #(.ID_VALUE(TB_ID)) dut (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .wr_valid(wr_valid),
      .wr_byte(wr_byte), .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
      .result_valid(result_valid), .result_bus(result_bus), .irq_set(irq_set),
      .en_power(en_power), .en_meas(en_meas), .en_wait(en_wait), .en_irq(en_irq),
      .integ_time(integ_time), .wait_time(wait_time), .thr_low(thr_low),
      .thr_high(thr_high), .persist(persist), .wait_long(wait_long), .gain(gain),
      .irq_flag(irq_flag), .irq_out(irq_out));

   // {address, write data, expected readback}, all through type-00 commands
   localparam logic [23:0] VEC [14] = '{
      24'h00FF1B, 24'h013737, 24'h03A5A5, 24'h041111, 24'h052222,
      24'h063333, 24'h074444, 24'h0CFF0F, 24'h0DFF02, 24'h0FFF03,
      24'h1200C3, 24'h027700, 24'h1E5500, 24'h13FF00};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start();
      @(negedge clk); xfer_start = 1'b1;
      @(posedge clk); #1 xfer_start = 1'b0;
   endtask

   task automatic wbyte(input logic [7:0] b);
      @(negedge clk); wr_valid = 1'b1; wr_byte = b;
      @(posedge clk); #1 wr_valid = 1'b0;
   endtask

   task automatic rbyte(output logic [7:0] r);
      @(negedge clk); rd_req = 1'b1;
      @(posedge clk); #1 rd_req = 1'b0;
      r = rd_data;
      check("R11 rd_valid", {31'b0, rd_valid}, 32'd1);
   endtask

   task automatic results(input logic [63:0] v);
      @(negedge clk); result_valid = 1'b1; result_bus = v;
      @(posedge clk); #1 result_valid = 1'b0;
   endtask

   task automatic pulse_irq();
      @(negedge clk); irq_set = 1'b1;
      @(posedge clk); #1 irq_set = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R12: reset state
      check("R12 integ_time", integ_time, 32'hFF);
      check("R12 wait_time", wait_time, 32'hFF);
      check("R12 irq_out", {31'b0, irq_out}, 0);
      check("R12 thr_low", thr_low, 0);
      start(); rbyte(rb);
      check("R12 pointer 0 read", rb, 0);

      // R6 R7: table walk
      for (int i = 0; i < 14; i++) begin
         start(); wbyte({3'b100, VEC[i][20:16]}); wbyte(VEC[i][15:8]);
         start(); wbyte({3'b100, VEC[i][20:16]});
         start(); rbyte(rb);
         check($sformatf("R6 R7 addr %0h", VEC[i][23:16]), rb, VEC[i][7:0]);
      end
      check("R6 enable bits", {28'b0, en_irq, en_wait, en_meas, en_power}, 32'hF);
      check("R6 persist", persist, 32'hF);
      check("R6 wait_long", {31'b0, wait_long}, 1);
      check("R6 gain", gain, 3);
      check("R6 integ/wait", {integ_time, wait_time}, 32'h37A5);
      check("R6 thresholds", {thr_high, thr_low}, 32'h44332211);

      // R3: auto-increment writes
      start(); wbyte(8'hA4);
      wbyte(8'h9A); wbyte(8'hBC); wbyte(8'hDE); wbyte(8'hF0);
      check("R3 auto write thresholds", {thr_high, thr_low}, 32'hF0DEBC9A);

      // R1 R4 R11: command not stored; data-first byte uses stored pointer
      start(); wbyte(8'h81);
      check("R1 command not data", integ_time, 32'h37);
      start(); wbyte(8'h5C);
      check("R4 data at stored pointer", integ_time, 32'h5C);
      start(); rbyte(rb);
      check("R4 read at stored pointer", rb, 32'h5C);

      // R2: repeated access
      rbyte(rb);
      check("R2 repeated read", rb, 32'h5C);
      wbyte(8'h11); wbyte(8'h22);
      check("R2 repeated write", integ_time, 32'h22);
      check("R2 neighbour untouched", wait_time, 32'hA5);

      // R3 R7: wrap 0x1F -> 0x00
      start(); wbyte(8'hBF); rbyte(rb);
      check("R7 unmapped read 1F", rb, 0);
      rbyte(rb);
      check("R3 wrap to enable", rb, 32'h1B);

      // R8: result channels
      results(64'hDEF0_9ABC_5678_1234);
      start(); wbyte(8'hB4);
      begin
         logic [63:0] exp_b;
         exp_b = 64'hDEF0_9ABC_5678_1234;
         for (int k = 0; k < 8; k++) begin
            rbyte(rb);
            check($sformatf("R8 data byte %0d", k), rb, exp_b[k*8 +: 8]);
         end
      end
      start(); wbyte(8'h93); rbyte(rb);
      check("R8 status valid", rb, 32'h01);

      // R9: shadow holds across new results
      start(); wbyte(8'hB4); rbyte(rb);
      check("R9 low byte", rb, 32'h34);
      results(64'hDEF0_9ABC_5678_AAAA);
      rbyte(rb);
      check("R9 shadow high", rb, 32'h12);

      // R9: low read coinciding with new results
      start(); wbyte(8'hB4);
      @(negedge clk); rd_req = 1'b1; result_valid = 1'b1; result_bus = 64'hDEF0_9ABC_5678_5555;
      @(posedge clk); #1 rd_req = 1'b0; result_valid = 1'b0;
      check("R9 same-cycle low byte old", rd_data, 32'hAA);
      rbyte(rb);
      check("R9 same-cycle high byte old", rb, 32'hAA);
      start(); wbyte(8'hB4); rbyte(rb);
      check("R9 fresh low byte", rb, 32'h55);

      // R10 R5: interrupt flag
      pulse_irq();
      check("R10 irq_out", {31'b0, irq_out}, 1);
      start(); wbyte(8'h93); rbyte(rb);
      check("R10 status irq bit", rb, 32'h11);
      start(); wbyte(8'hE1);
      check("R5 other code no effect", {31'b0, irq_flag}, 1);
      start(); wbyte(8'hE6);
      check("R5 clear flag", {30'b0, irq_flag, irq_out}, 0);
      start(); rbyte(rb);
      check("R5 pointer kept", rb, 32'h01);
      @(negedge clk); irq_set = 1'b1; wr_valid = 1'b1; wr_byte = 8'hE6; xfer_start = 1'b0;
      start();
      @(negedge clk); irq_set = 1'b1; wr_valid = 1'b1; wr_byte = 8'hE6;
      @(posedge clk); #1 irq_set = 1'b0; wr_valid = 1'b0;
      check("R10 set wins over clear", {31'b0, irq_flag}, 1);

      // R10: enable gating
      start(); wbyte(8'h80); wbyte(8'h01);
      check("R10 gated off", {30'b0, irq_flag, irq_out}, 32'h2);

      summary();
   end

endmodule